// File: doc/BRIEF.md
# Display RAM Host Register Interface

This block sits between a microprocessor bus and the graphics RAM of a display controller. Each host access is one strobe cycle carrying a register-select bit, a read/write bit and a 16-bit data word. With register select low, a write loads the index register, which selects the target of the following data accesses. With register select high, a write passes through a write-data stage. Depending on the index, it loads the address counter, stores a word into graphics RAM, or goes out on a control-register write port. A read with register select high returns the read-data register.

The read-data register is refilled from RAM through a one-stage pipeline. Each read strobe returns what the register held and starts a fetch at the address counter. So the first read after an address load gives a dummy value, and later reads stream the sequential words. The address counter steps after every RAM write. After a read it steps only when a mode bit allows. A direction bit picks increment or decrement, and the counter wraps modulo the RAM depth. The host may issue one access in every clock cycle.

Top module: `dispram_host_if`

## Requirements
- R1: A strobe with select low and write stores the low 8 data bits as the index. It produces no RAM write and no control write.
- R2: A strobe with select low and read changes no state: the index, mode, address counter and read-data register keep their values. It drives `hst_rdata` to zero one cycle later.
- R3: A select-high write under any index other than 0x21 or 0x22 pulses `ctl_wen` for one cycle, one cycle later, with the index and the data. Under index 0x03 it also loads the mode: data bit 0 = 1 selects decrement, and data bit 1 = 1 lets reads step the counter.
- R4: A select-high write under index 0x22 commits the word with no further host action. One cycle later `mem_wen` is high, with `mem_waddr` equal to the counter value before the step and `mem_wdata` equal to the data.
- R5: A select-high write under index 0x21 loads the low RAM_AW data bits into the address counter and clears the read-data register. The next read therefore returns 0 (dummy read).
- R6: A select-high read raises `mem_ren` in the same cycle, with `mem_raddr` equal to the counter. One cycle later, `hst_rdata` shows the read-data register, which holds the word fetched by the previous read. This holds even for back-to-back reads.
- R7: After each RAM write, the counter moves by one in the direction set by the mode, wrapping modulo 2^RAM_AW. `mem_raddr` always shows the counter.
- R8: After a read, the counter steps in the set direction if mode bit 1 is set, and holds if it is clear.
- R9: Accesses on consecutive cycles are all accepted. Back-to-back RAM writes produce a commit on each consecutive cycle.
- R10: After reset, `hst_rdata`, the counter, the index, the mode and the read-data register are zero, and `mem_wen` and `ctl_wen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_stb | input | 1 | Host access strobe, one cycle per access |
| hst_rs | input | 1 | Register select: 0 index, 1 data |
| hst_rd | input | 1 | 1 read, 0 write |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, registered |
| mem_ren | output | 1 | RAM read enable |
| mem_raddr | output | RAM_AW | RAM read address (address counter) |
| mem_rdata | input | 16 | RAM read data, one cycle after `mem_ren` |
| mem_wen | output | 1 | RAM write enable, registered |
| mem_waddr | output | RAM_AW | RAM write address |
| mem_wdata | output | 16 | RAM write data |
| ctl_wen | output | 1 | Control register write strobe |
| ctl_idx | output | 8 | Control register index |
| ctl_wdata | output | 16 | Control register write data |

## Verification
`mem_ren` and the address counter on `mem_raddr` are combinational, so they are compared in the strobe's own cycle, shortly after the inputs change. `hst_rdata`, `mem_wen` and `ctl_wen` are due one clock after the strobe. The read-data word is due one read later, because a fetch lands one edge after its strobe. The bench's reference model advances once per clock and samples the registered results two nanoseconds after the following rising edge. Each access therefore has its outputs checked before the next access is driven, and dummy reads after address loads are predicted as zero.

// File: rtl/dispram_pkg.sv
package dispram_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int IDX_W_DEF  = 8;
  localparam logic [7:0] IDX_ADDR_SET = 8'h21;
  localparam logic [7:0] IDX_RAM_PORT = 8'h22;
  localparam logic [7:0] IDX_MODE     = 8'h03;

  typedef struct packed {
    logic idx_wr;
    logic ld_ac;
    logic ram_wr;
    logic ctl_wr;
    logic mode_wr;
    logic rd_ram;
    logic rd_null;
  } dispram_cmd_t;
endpackage

// File: rtl/dispram_decode.sv
module dispram_decode
  import dispram_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             rs,
  input  logic             rd,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [1:0]       mode_in,
  output dispram_cmd_t     cmd,
  output logic [IDX_W-1:0] idx_q,
  output logic             mode_dec,
  output logic             mode_radv
);
  localparam logic [IDX_W-1:0] K_ADDR = IDX_W'(IDX_ADDR_SET);
  localparam logic [IDX_W-1:0] K_RAM  = IDX_W'(IDX_RAM_PORT);
  localparam logic [IDX_W-1:0] K_MODE = IDX_W'(IDX_MODE);

  logic data_wr;

  always_comb begin
    data_wr     = stb && rs && !rd;
    cmd.idx_wr  = stb && !rs && !rd;
    cmd.rd_null = stb && !rs && rd;
    cmd.rd_ram  = stb && rs && rd;
    cmd.ld_ac   = data_wr && (idx_q == K_ADDR);
    cmd.ram_wr  = data_wr && (idx_q == K_RAM);
    cmd.ctl_wr  = data_wr && (idx_q != K_ADDR) && (idx_q != K_RAM);
    cmd.mode_wr = data_wr && (idx_q == K_MODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      mode_dec  <= 1'b0;
      mode_radv <= 1'b0;
    end else begin
      if (cmd.idx_wr) idx_q <= idx_in;
      if (cmd.mode_wr) begin
        mode_dec  <= mode_in[0];
        mode_radv <= mode_in[1];
      end
    end
  end

  AST_NULL_KEEPS_INDEX: assert property (@(posedge clk) disable iff (rst)
    cmd.rd_null |=> $stable(idx_q) && $stable(mode_dec) && $stable(mode_radv)); // R2
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (stb && !rs && !rd) |=> idx_q == $past(idx_in)); // R1
endmodule

// File: rtl/dispram_addr_ctr.sv
module dispram_addr_ctr #(
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [RAM_AW-1:0] ld_val,
  input  logic              wr_step,
  input  logic              rd_evt,
  input  logic              radv,
  input  logic              dec,
  output logic [RAM_AW-1:0] ac
);
  localparam logic [RAM_AW-1:0] ONE = RAM_AW'(1);

  logic step;
  assign step = wr_step || (rd_evt && radv);

  always_ff @(posedge clk) begin
    if (rst)       ac <= '0;
    else if (ld)   ac <= ld_val;
    else if (step) ac <= dec ? ac - ONE : ac + ONE;
  end

  AST_AC_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_step |=> ac == ($past(dec) ? $past(ac) - ONE : $past(ac) + ONE)); // R7
  AST_AC_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && !radv) |=> $stable(ac)); // R8
  AST_AC_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && radv) |=> ac != $past(ac)); // R8
endmodule

// File: rtl/dispram_write_stage.sv
module dispram_write_stage #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ram_wr,
  input  logic              ctl_wr,
  input  logic [RAM_AW-1:0] ac,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  output logic              mem_wen,
  output logic [RAM_AW-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ctl_wen,
  output logic [IDX_W-1:0]  ctl_idx,
  output logic [DATA_W-1:0] ctl_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wen <= 1'b0;
      ctl_wen <= 1'b0;
    end else begin
      mem_wen <= ram_wr;
      ctl_wen <= ctl_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (ram_wr) begin
      mem_waddr <= ac;
      mem_wdata <= data;
    end
    if (ctl_wr) begin
      ctl_idx   <= idx;
      ctl_wdata <= data;
    end
  end

  AST_WR_COMMIT: assert property (@(posedge clk) disable iff (rst)
    ram_wr |=> mem_wen && mem_wdata == $past(data) && mem_waddr == $past(ac)); // R4
  AST_CTL_PULSE: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ctl_wen && !mem_wen && ctl_idx == $past(idx)); // R3
endmodule

// File: rtl/dispram_read_pipe.sv
module dispram_read_pipe #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ram,
  input  logic              rd_null,
  input  logic              ld,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] hst_rdata
);
  logic              fill_q;
  logic [DATA_W-1:0] rdr_q;
  logic [DATA_W-1:0] rdr_view;

  assign rdr_view = fill_q ? mem_rdata : rdr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q    <= 1'b0;
      rdr_q     <= '0;
      hst_rdata <= '0;
    end else begin
      fill_q <= rd_ram;
      if (ld)          rdr_q <= '0;
      else if (fill_q) rdr_q <= mem_rdata;
      if (rd_ram)       hst_rdata <= rdr_view;
      else if (rd_null) hst_rdata <= '0;
    end
  end

  AST_LOAD_CLEARS_RDR: assert property (@(posedge clk) disable iff (rst)
    ld |=> rdr_q == '0); // R5
  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_null |=> hst_rdata == '0); // R2
  AST_NULL_KEEPS_RDR: assert property (@(posedge clk) disable iff (rst)
    (rd_null && !fill_q) |=> $stable(rdr_q)); // R2
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (rd_ram && !fill_q) |=> hst_rdata == $past(rdr_q)); // R6
endmodule

// File: rtl/dispram_host_if.sv
module dispram_host_if
  import dispram_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int IDX_W  = IDX_W_DEF,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_stb,
  input  logic              hst_rs,
  input  logic              hst_rd,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              mem_ren,
  output logic [RAM_AW-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wen,
  output logic [RAM_AW-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ctl_wen,
  output logic [IDX_W-1:0]  ctl_idx,
  output logic [DATA_W-1:0] ctl_wdata
);
  dispram_cmd_t      cmd;
  logic [IDX_W-1:0]  idx_q;
  logic              mode_dec;
  logic              mode_radv;
  logic [RAM_AW-1:0] ac;

  dispram_decode #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .stb(hst_stb), .rs(hst_rs), .rd(hst_rd),
    .idx_in(hst_wdata[IDX_W-1:0]), .mode_in(hst_wdata[1:0]),
    .cmd(cmd), .idx_q(idx_q), .mode_dec(mode_dec), .mode_radv(mode_radv)
  );

  dispram_addr_ctr #(.RAM_AW(RAM_AW)) u_ac (
    .clk(clk), .rst(rst), .ld(cmd.ld_ac), .ld_val(hst_wdata[RAM_AW-1:0]),
    .wr_step(cmd.ram_wr), .rd_evt(cmd.rd_ram), .radv(mode_radv),
    .dec(mode_dec), .ac(ac)
  );

  dispram_write_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W), .RAM_AW(RAM_AW)) u_wr (
    .clk(clk), .rst(rst), .ram_wr(cmd.ram_wr), .ctl_wr(cmd.ctl_wr),
    .ac(ac), .idx(idx_q), .data(hst_wdata),
    .mem_wen(mem_wen), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ctl_wen(ctl_wen), .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata)
  );

  dispram_read_pipe #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_ram(cmd.rd_ram), .rd_null(cmd.rd_null),
    .ld(cmd.ld_ac), .mem_rdata(mem_rdata), .hst_rdata(hst_rdata)
  );

  assign mem_ren   = cmd.rd_ram;
  assign mem_raddr = ac;

  AST_NULL_KEEPS_AC: assert property (@(posedge clk) disable iff (rst)
    (hst_stb && !hst_rs && hst_rd) |=> $stable(mem_raddr) && !mem_wen && !ctl_wen); // R2
  AST_INDEX_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (hst_stb && !hst_rs && !hst_rd) |=> !mem_wen && !ctl_wen); // R1
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wen, ctl_wen})); // R3
endmodule

// File: tb/dispram_host_if_test.sv
`timescale 1ns/1ps
module dispram_host_if_test;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0, rs = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] hst_rdata, mem_rdata, mem_wdata, ctl_wdata;
  logic mem_ren, mem_wen, ctl_wen;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [7:0] ctl_idx;

  always #4 clk = ~clk;

  dispram_host_if #(.RAM_AW(AW)) uut (
    .clk(clk), .rst(rst), .hst_stb(stb), .hst_rs(rs), .hst_rd(rd),
    .hst_wdata(wdata), .hst_rdata(hst_rdata), .mem_ren(mem_ren),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_wen(mem_wen),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .ctl_wen(ctl_wen),
    .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata)
  );

  // environment RAM: one-cycle read latency, read before write
  logic [15:0] ram [DEPTH];
  always @(posedge clk) begin
    if (mem_ren) mem_rdata <= ram[mem_raddr];
    if (mem_wen) ram[mem_waddr] <= mem_wdata;
  end

  // reference model state
  int m_mem [DEPTH];
  int m_ac, m_idx, m_rdr, m_fillv, m_rdata;
  bit m_fill, m_dec, m_radv;
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit r, input bit w_rd, input int d, input string tag);
    bit e_wen, e_cwen;
    int e_waddr, e_wdata, new_rdr;
    bit nfill;
    @(negedge clk);
    stb = s; rs = r; rd = w_rd; wdata = d[15:0];
    #1;
    chk(tag, "mem_ren", mem_ren, s & r & w_rd);
    chk(tag, "mem_raddr", mem_raddr, m_ac);
    e_wen = 0; e_cwen = 0; e_waddr = 0; e_wdata = 0; nfill = 0;
    new_rdr = m_fill ? m_fillv : m_rdr;
    if (s && !r && !w_rd) m_idx = d & 8'hff;
    else if (s && !r && w_rd) m_rdata = 0;
    else if (s && r && !w_rd) begin
      if (m_idx == 'h21) begin
        m_ac = d % DEPTH; new_rdr = 0;
      end else if (m_idx == 'h22) begin
        e_wen = 1; e_waddr = m_ac; e_wdata = d & 16'hffff;
        m_mem[m_ac] = d & 16'hffff;
        m_ac = m_dec ? (m_ac + DEPTH - 1) % DEPTH : (m_ac + 1) % DEPTH;
      end else begin
        e_cwen = 1;
        if (m_idx == 'h03) begin m_dec = d[0]; m_radv = d[1]; end
      end
    end else if (s && r && w_rd) begin
      m_rdata = new_rdr; nfill = 1; m_fillv = m_mem[m_ac];
      if (m_radv) m_ac = m_dec ? (m_ac + DEPTH - 1) % DEPTH : (m_ac + 1) % DEPTH;
    end
    m_rdr = new_rdr; m_fill = nfill;
    @(posedge clk); #2;
    chk(tag, "hst_rdata", hst_rdata, m_rdata);
    chk(tag, "mem_wen", mem_wen, e_wen);
    chk(tag, "ctl_wen", ctl_wen, e_cwen);
    if (e_wen) begin
      chk(tag, "mem_waddr", mem_waddr, e_waddr);
      chk(tag, "mem_wdata", mem_wdata, e_wdata);
    end
    if (e_cwen) begin
      chk(tag, "ctl_idx", ctl_idx, m_idx);
      chk(tag, "ctl_wdata", ctl_wdata, d & 16'hffff);
    end
  endtask

  task automatic idx(input int v, input string tag);  step(1, 0, 0, v, tag); endtask
  task automatic wr(input int v, input string tag);   step(1, 1, 0, v, tag); endtask
  task automatic rdm(input string tag);               step(1, 1, 1, 0, tag); endtask

  initial begin
    int lf;
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = 16'((i * 37 + 5) ^ 16'h5a00);
      m_mem[i] = int'(ram[i]);
    end
    m_ac = 0; m_idx = 0; m_rdr = 0; m_fill = 0; m_fillv = 0; m_rdata = 0; m_dec = 0; m_radv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R10 reset state
    chk("R10", "hst_rdata", hst_rdata, 0);
    chk("R10", "mem_wen", mem_wen, 0);
    chk("R10", "ctl_wen", ctl_wen, 0);
    chk("R10", "ac", mem_raddr, 0);
    // R1 index write, R5 address load, dummy read then data (hold mode, R8)
    idx('h21, "R1");
    wr('h0005, "R5");
    rdm("R5");
    rdm("R6");
    rdm("R8");
    // R3 mode write: reads now advance
    idx('h03, "R1");
    wr('h0002, "R3");
    idx('h21, "R1");
    wr('h000a, "R5");
    rdm("R5");
    rdm("R6");
    rdm("R6");
    rdm("R8");
    // R2 disabled combination
    step(1, 0, 1, 'hffff, "R2");
    rdm("R2");
    // R4 R9 back-to-back RAM writes
    idx('h22, "R1");
    wr('h1111, "R9");
    wr('h2222, "R9");
    wr('h3333, "R4");
    // R7 decrement with wrap
    idx('h03, "R1");
    wr('h0003, "R3");
    idx('h21, "R1");
    wr('h0001, "R5");
    idx('h22, "R1");
    wr('hbeef, "R7");
    wr('hcafe, "R7");
    wr('hf00d, "R7");
    // read back the written words going down
    idx('h21, "R1");
    wr('h0001, "R5");
    rdm("R5");
    rdm("R6");
    rdm("R6");
    rdm("R7");
    // plain control register
    idx('h40, "R1");
    wr('h1234, "R3");
    // mixed traffic
    lf = 'hace1;
    for (int n = 0; n < 400; n++) begin
      lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 'hffff;
      case (lf & 7)
        0: case ((lf >> 3) & 3)
             0: idx('h21, "R1");
             1: idx('h22, "R1");
             2: idx('h03, "R1");
             default: idx('h41, "R1");
           endcase
        1: step(1, 0, 1, lf, "R2");
        2, 3: wr(lf, "R9");
        4, 5, 6: rdm("R6");
        default: step(0, 1, 1, lf, "R9");
      endcase
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule